// File: doc/BRIEF.md
# Power-Fail Detect Controller

This block supervises a digital low-supply flag that an external comparator raises when the supply rail drops too far. The flag is synchronized and then filtered, so only a low-supply condition that stays present for more than a set number of clock cycles counts as a power failure. Shorter glitches are discarded.

When a failure is confirmed, the block takes one of two actions, chosen by a mode bit. In the first, it holds the system clock enable low for as long as the failure lasts. In the second, it issues a fixed-length system reset request. In both cases it sets a sticky status bit. The reset the block causes does not clear that bit, so boot code can read it and skip its full initialization after a power-fail restart. Only the power-on reset clears the bit through hardware.

Software reaches the block through one byte-wide register at a fixed address. The register holds a disable bit, a mode bit and the status bit.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: After power-on reset, the register at address 0xEF reads 0x04. The fields are: bits 7:3 read 0, bit 2 (disable) is 1, bit 1 (mode) is 0 and bit 0 (status) is 0. After the same reset, clk_en is 1 and rst_req is 0.
- R2: While bit 2 is 1, a low-supply condition of any length leaves the status bit unchanged, keeps clk_en at 1 and keeps rst_req at 0.
- R3: supply_low must stay high for more than FILT_CYC consecutive clocks (default 5) to confirm a failure. A pulse of FILT_CYC cycles or fewer has no effect on the outputs or on the status bit.
- R4: With bit 1 = 0, a supply_low pulse of L > FILT_CYC cycles drives clk_en low for exactly L - FILT_CYC consecutive cycles. clk_en then returns to 1.
- R5: With bit 1 = 1, each confirmed failure raises rst_req for exactly RST_CYC cycles (default 4), however long the failure lasts. clk_en stays at 1.
- R6: A confirmed failure sets bit 0 to 1 in either mode.
- R7: A write to 0xEF loads bits 2:1 from the write data. Writing 0 to bit 0 clears the status bit. Writing 1 to bit 0 leaves it unchanged.
- R8: A low level on sys_rst_n sets bits 2:1 back to 1 and 0 and clears the filter. It does not change the status bit.
- R9: If a software clear of the status bit falls in a cycle in which a failure is confirmed, the status bit stays 1.
- R10: Writes to any address other than 0xEF have no effect. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| sys_rst_n | input | 1 | Synchronous system reset, active low; status is kept |
| supply_low | input | 1 | Asynchronous low-supply flag from the comparator |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| clk_en | output | 1 | System clock enable; low while a failure is frozen |
| rst_req | output | 1 | System reset request pulse |

## Verification
The low-supply input is driven with pulses of exactly the filter length, one cycle longer, a medium length and a long one. The filter-length pulse separates rejection from acceptance at the boundary. The longer pulses show that the freeze length follows the pulse while the reset pulse keeps a fixed length. Each pattern runs with detection enabled in both modes and again with detection disabled. Status writes are placed while a failure is active and after it has ended, which separates the hardware set taking priority from a software clear that takes effect.

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF,
  parameter int FILT_CYC = 5,
  parameter int RST_CYC  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_en,
  output logic              rst_req
);
  localparam int CNT_W  = $clog2(FILT_CYC + 1);
  localparam int RCNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0]  RUN_MAX   = CNT_W'(FILT_CYC);
  localparam logic [RCNT_W-1:0] PULSE_LEN = RCNT_W'(RST_CYC);

  logic [1:0]        sync_q;
  logic [CNT_W-1:0]  run_q;
  logic [RCNT_W-1:0] pulse_q;
  logic              dis_q, mode_q, stat_q, conf_d;
  logic              ce_q;

  wire sel    = (bus_addr == REG_ADDR);
  wire wr_hit = bus_wr && sel;
  wire conf   = sync_q[1] && (run_q == RUN_MAX) && !dis_q;

  assign bus_rdata = sel ? {{(DATA_W-3){1'b0}}, dis_q, mode_q, stat_q} : '0;
  assign clk_en    = ce_q;
  assign rst_req   = (pulse_q != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q  <= '0;
      run_q   <= '0;
      pulse_q <= '0;
      dis_q   <= 1'b1;
      mode_q  <= 1'b0;
      stat_q  <= 1'b0;
      conf_d  <= 1'b0;
      ce_q    <= 1'b1;
    end else if (!sys_rst_n) begin
      sync_q  <= '0;
      run_q   <= '0;
      pulse_q <= '0;
      dis_q   <= 1'b1;
      mode_q  <= 1'b0;
      conf_d  <= 1'b0;
      ce_q    <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], supply_low};

      if (!sync_q[1] || dis_q)  run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;

      conf_d <= conf;
      ce_q   <= !(conf && !mode_q);

      if (conf && !conf_d && mode_q) pulse_q <= PULSE_LEN;
      else if (pulse_q != '0)        pulse_q <= pulse_q - 1'b1;

      if (conf)                        stat_q <= 1'b1;
      else if (wr_hit && !bus_wdata[0]) stat_q <= 1'b0;

      if (wr_hit) begin
        dis_q  <= bus_wdata[2];
        mode_q <= bus_wdata[1];
      end
    end
  end
endmodule

module pfs_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
  input logic              clk,
  input logic              por_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              clk_en,
  input logic              rst_req,
  input logic              dis_q,
  input logic              mode_q,
  input logic              stat_q,
  input logic              conf
);
  wire clr_try = bus_wr && (bus_addr == REG_ADDR) && !bus_wdata[0];

  a_r2_disabled_no_freeze: assert property (@(posedge clk) disable iff (!por_n)
    dis_q |=> clk_en);
  a_r2_disabled_no_reset: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(!dis_q));
  a_r4_freeze_only_mode0: assert property (@(posedge clk) disable iff (!por_n)
    $fell(clk_en) |-> $past(!mode_q));
  a_r5_reset_only_mode1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(mode_q));
  a_r6_status_set: assert property (@(posedge clk) disable iff (!por_n)
    conf |=> stat_q);
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (stat_q && !clr_try) |=> stat_q);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!por_n)
    (conf && clr_try) |=> stat_q);
endmodule

bind pwr_fail_supervisor pfs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .clk_en(clk_en), .rst_req(rst_req), .dis_q(dis_q), .mode_q(mode_q), .stat_q(stat_q),
  .conf(conf)
);

// File: tb/pwr_fail_supervisor_tb_top.sv
`timescale 1ns/1ps
module pwr_fail_supervisor_tb_top;
  localparam int F = 5;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, sys_rst_n = 1'b1, supply_low = 1'b0;
  logic [7:0] bus_addr = 8'hEF, bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       clk_en, rst_req;

  int checks = 0, failures = 0;
  int low_cnt = 0, req_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_fail_supervisor #(.FILT_CYC(F), .RST_CYC(P)) dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .supply_low(supply_low),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en(clk_en), .rst_req(rst_req)
  );

  // behavioural reference model
  int m_in1, m_in2, m_held, m_pulse, m_dis, m_mode, m_stat, m_prev, m_ce;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    return (a == 8'hEF) ? 8'((m_dis << 2) | (m_mode << 1) | m_stat) : 8'h00;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int confirmed;
    if (!por_n) begin
      m_in1 = 0; m_in2 = 0; m_held = 0; m_pulse = 0; m_dis = 1; m_mode = 0;
      m_stat = 0; m_prev = 0; m_ce = 1;
    end else if (!sys_rst_n) begin
      m_in1 = 0; m_in2 = 0; m_held = 0; m_pulse = 0; m_dis = 1; m_mode = 0;
      m_prev = 0; m_ce = 1;
    end else begin
      confirmed = (m_in2 != 0 && m_held >= F && m_dis == 0) ? 1 : 0;
      m_held = (m_in2 == 0 || m_dis != 0) ? 0 : ((m_held < F) ? m_held + 1 : F);
      m_in2 = m_in1;
      m_in1 = supply_low;
      m_ce = (confirmed != 0 && m_mode == 0) ? 0 : 1;
      if (confirmed != 0 && m_prev == 0 && m_mode != 0) m_pulse = P;
      else if (m_pulse > 0) m_pulse--;
      if (confirmed != 0) m_stat = 1;
      else if (bus_wr && bus_addr == 8'hEF && !bus_wdata[0]) m_stat = 0;
      if (bus_wr && bus_addr == 8'hEF) begin
        m_dis = bus_wdata[2];
        m_mode = bus_wdata[1];
      end
      m_prev = confirmed;
    end
    #2;
    check("R4 clk_en model", clk_en, m_ce);
    check("R5 rst_req model", rst_req, m_pulse > 0);
    check("R7 rdata model", bus_rdata, m_read(bus_addr));
    if (!clk_en) low_cnt++;
    if (rst_req) req_cnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'hEF;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    bus_addr = 8'hEF;
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    low_cnt = 0; req_cnt = 0;
    supply_low = 1'b1;
    repeat (len) @(negedge clk);
    supply_low = 1'b0;
    repeat (F + P + 10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(8'hEF, 8'h04, "R1 reset value");
    check("R1 clk_en after reset", clk_en, 1);
    check("R1 rst_req after reset", rst_req, 0);
    rd(8'h10, 8'h00, "R10 other address reads 0");

    wr(8'hEF, 8'h00);
    rd(8'hEF, 8'h00, "R7 enable freeze mode");
    pulse(F);
    check("R3 glitch no freeze", low_cnt, 0);
    rd(8'hEF, 8'h00, "R3 glitch no status");
    pulse(F + 1);
    check("R3 just over filter freezes", low_cnt, 1);
    rd(8'hEF, 8'h01, "R6 status set freeze mode");
    wr(8'hEF, 8'h00);
    rd(8'hEF, 8'h00, "R7 write 0 clears status");
    pulse(12);
    check("R4 freeze length", low_cnt, 12 - F);
    check("R4 no reset in freeze mode", req_cnt, 0);
    wr(8'h10, 8'h00);
    rd(8'hEF, 8'h01, "R10 foreign write ignored");
    wr(8'hEF, 8'h01);
    rd(8'hEF, 8'h01, "R7 write 1 keeps status");

    @(negedge clk);
    supply_low = 1'b1;
    repeat (15) @(negedge clk);
    wr(8'hEF, 8'h00);
    rd(8'hEF, 8'h01, "R9 set beats clear");
    supply_low = 1'b0;
    repeat (15) @(negedge clk);

    wr(8'hEF, 8'h03);
    rd(8'hEF, 8'h03, "R7 reset mode selected");
    pulse(12);
    check("R5 reset pulse length", req_cnt, P);
    check("R5 no freeze in reset mode", low_cnt, 0);
    rd(8'hEF, 8'h03, "R6 status set reset mode");
    wr(8'hEF, 8'h02);
    rd(8'hEF, 8'h02, "R7 clear in reset mode");
    pulse(30);
    check("R5 single pulse on long failure", req_cnt, P);

    @(negedge clk);
    sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    rd(8'hEF, 8'h05, "R8 system reset keeps status");

    wr(8'hEF, 8'h04);
    rd(8'hEF, 8'h04, "R2 disabled and cleared");
    pulse(20);
    check("R2 disabled no freeze", low_cnt, 0);
    check("R2 disabled no reset", req_cnt, 0);
    rd(8'hEF, 8'h04, "R2 disabled no status");

    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rd(8'hEF, 8'h04, "R1 power-on reset clears all");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule